// File: doc/BRIEF.md
# Registered Bidirectional Byte-Lane Transceiver

This block links an A port and a B port through non-inverting channels. The channels are grouped into independent byte lanes, and each lane has its own controls. A lane holds two registers. The A-to-B register stores A-side data, and the B-to-A register stores B-side data. The port a lane drives can carry either the live value from the opposite port or the stored register contents. A lane can also be isolated so that neither port is driven. Its registers keep capturing while it is isolated.

The block has no tri-state pins. Each port is split into a data-in bus, a data-out bus and a per-lane drive enable. A pad ring or bus fabric combines them into a real bidirectional wire. Capture strobes are sampled on the block clock, and a rising edge of a strobe stores the opposite port's input. Directions, selects and enables act combinationally on the outputs. Each data-out bus always presents its selected value, and the drive enable alone decides whether that value reaches the wire.

Top module: `xcvr_bus`

## Requirements
- R1: There are 16 channels in two 8-bit lanes. Lane k occupies bits [8k+7:8k] of every data bus and bit k of every control and enable. Nothing in one lane affects the other lane's outputs or registers.
- R2: A capture into a lane's A-to-B register happens at a clock edge where cap_ab is sampled 1 after being 0 at the previous edge. The register then holds that lane's a_in value from the capture edge.
- R3: A capture into a lane's B-to-A register happens at a clock edge where cap_ba is sampled 1 after being 0 at the previous edge. The register then holds that lane's b_in value from the capture edge.
- R4: While a lane's oe_n is 1, the lane is isolated, and both a_drv and b_drv for that lane are 0.
- R5: While oe_n is 0, dir = 1 gives b_drv = 1 and a_drv = 0, and dir = 0 gives a_drv = 1 and b_drv = 0. The two enables of a lane are never 1 together.
- R6: b_out for a lane shows the lane's live a_in in the same cycle when sel_ab = 0. It shows the A-to-B register when sel_ab = 1.
- R7: a_out for a lane shows the lane's live b_in in the same cycle when sel_ba = 0. It shows the B-to-A register when sel_ba = 1.
- R8: Captures happen whatever the values of oe_n and dir. A value captured while a lane is isolated appears on the driven port once the lane is enabled with sel = 1.
- R9: A clock edge that samples rst_n = 0 clears every register to zero. No capture happens at such an edge, and a strobe that is held high through reset does not capture when reset is released.
- R10: A strobe held at 1 over several edges captures only once. Later changes on the input leave the register unchanged until the strobe has returned to 0 and risen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | 2 | Per-lane active-low enable; 1 isolates the lane |
| dir | input | 2 | Per-lane direction; 1 drives B, 0 drives A |
| cap_ab | input | 2 | Per-lane strobe; a rising edge stores a_in |
| cap_ba | input | 2 | Per-lane strobe; a rising edge stores b_in |
| sel_ab | input | 2 | Per-lane source for b_out: 0 live, 1 stored |
| sel_ba | input | 2 | Per-lane source for a_out: 0 live, 1 stored |
| a_in | input | 16 | Value seen on the A wire |
| b_in | input | 16 | Value seen on the B wire |
| a_out | output | 16 | Value offered to the A wire |
| a_drv | output | 2 | Per-lane drive enable for the A wire |
| b_out | output | 16 | Value offered to the B wire |
| b_drv | output | 2 | Per-lane drive enable for the B wire |

## Verification
The bench steps through all eight combinations of enable, direction and select on each lane. A design that swapped the direction or let isolation leak would then assert the wrong enable, or both enables at once. It captures while a lane is isolated and then enables the lane with stored select. A design that gated captures on the enable would then show zero or stale data. It holds a strobe high over several edges and through a reset release, which catches a level-sensitive capture that follows later input changes. A long randomized stretch runs the two lanes with unrelated controls, so any bleed between lanes shows up on the other lane's outputs.

// File: rtl/xcvr_pkg.sv
// Shared types for the byte-lane transceiver.
// Assumes: one control set per lane, all bits sampled on the block clock.
package xcvr_pkg;

    // Source choice for a driven port: live opposite input or stored register.
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    // Per-lane control bundle.
    typedef struct packed {
        logic oe_n;
        logic dir;
        logic cap_ab;
        logic cap_ba;
        logic sel_ab;
        logic sel_ba;
    } lane_ctrl_t;

endpackage

// File: rtl/xcvr_capture.sv
// Strobe-triggered storage register.
// Stores d when the strobe is sampled high after being sampled low.
// Assumes: strobe is synchronous to clk and stays at each level for at least one cycle.
// Reset clears the stored value and takes over the strobe level, so a strobe held
// high through reset does not count as a rising edge.
module xcvr_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic strobe_q;
    logic fire;

    // Rising-edge detect on the sampled strobe.
    assign fire = strobe & ~strobe_q;

    // Track the previous strobe level, also while reset is held.
    always_ff @(posedge clk) begin
        strobe_q <= strobe;
    end

    // Store on a detected rise; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (fire) begin
            q <= d;
        end
    end
endmodule

// File: rtl/xcvr_route.sv
// Output source select and drive enable for one side of one lane.
// DRIVE_DIR gives the dir level at which this side is driven.
// Assumes: oe_n is active low; out carries the selected value even when not driven.
module xcvr_route
    import xcvr_pkg::*;
#(
    parameter int W         = 8,
    parameter bit DRIVE_DIR = 1'b1
) (
    input  src_sel_e     sel,
    input  logic         oe_n,
    input  logic         dir,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] out,
    output logic         drv
);
    // Choose live or stored data.
    always_comb begin
        unique case (sel)
            SRC_STORED: out = stored;
            default:    out = live;
        endcase
    end

    // Drive only when enabled and dir points at this side.
    assign drv = ~oe_n & (dir == DRIVE_DIR);
endmodule

// File: rtl/xcvr_lane.sv
// One byte lane: two storage registers and two output routes.
// The A-to-B register feeds the B side; the B-to-A register feeds the A side.
// Assumes: controls come bundled per lane and are synchronous to clk.
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  lane_ctrl_t   ctrl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_drv,
    output logic [W-1:0] b_out,
    output logic         b_drv
);
    logic [W-1:0] q_ab;
    logic [W-1:0] q_ba;

    // A-side data stored for the B side.
    xcvr_capture #(.W(W)) u_cap_ab (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (ctrl.cap_ab),
        .d      (a_in),
        .q      (q_ab)
    );

    // B-side data stored for the A side.
    xcvr_capture #(.W(W)) u_cap_ba (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (ctrl.cap_ba),
        .d      (b_in),
        .q      (q_ba)
    );

    // B side is driven when dir is high.
    xcvr_route #(.W(W), .DRIVE_DIR(1'b1)) u_to_b (
        .sel    (src_sel_e'(ctrl.sel_ab)),
        .oe_n   (ctrl.oe_n),
        .dir    (ctrl.dir),
        .live   (a_in),
        .stored (q_ab),
        .out    (b_out),
        .drv    (b_drv)
    );

    // A side is driven when dir is low.
    xcvr_route #(.W(W), .DRIVE_DIR(1'b0)) u_to_a (
        .sel    (src_sel_e'(ctrl.sel_ba)),
        .oe_n   (ctrl.oe_n),
        .dir    (ctrl.dir),
        .live   (b_in),
        .stored (q_ba),
        .out    (a_out),
        .drv    (a_drv)
    );
endmodule

// File: rtl/xcvr_bus.sv
// Top: LANES independent byte lanes between an A port and a B port.
// Each port is split into data-in, data-out and a per-lane drive enable;
// the wire itself is formed outside this block.
// Assumes: all inputs synchronous to clk; rst_n synchronous, active low.
module xcvr_bus
    import xcvr_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES-1:0]          oe_n,
    input  logic [LANES-1:0]          dir,
    input  logic [LANES-1:0]          cap_ab,
    input  logic [LANES-1:0]          cap_ba,
    input  logic [LANES-1:0]          sel_ab,
    input  logic [LANES-1:0]          sel_ba,
    input  logic [LANES*LANE_W-1:0]   a_in,
    input  logic [LANES*LANE_W-1:0]   b_in,
    output logic [LANES*LANE_W-1:0]   a_out,
    output logic [LANES-1:0]          a_drv,
    output logic [LANES*LANE_W-1:0]   b_out,
    output logic [LANES-1:0]          b_drv
);
    localparam int W = LANES * LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_ctrl_t ctrl;

        // Bundle this lane's control bits.
        assign ctrl = '{
            oe_n:   oe_n[g],
            dir:    dir[g],
            cap_ab: cap_ab[g],
            cap_ba: cap_ba[g],
            sel_ab: sel_ab[g],
            sel_ba: sel_ba[g]
        };

        xcvr_lane #(.W(LANE_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .ctrl  (ctrl),
            .a_in  (a_in[g*LANE_W +: LANE_W]),
            .b_in  (b_in[g*LANE_W +: LANE_W]),
            .a_out (a_out[g*LANE_W +: LANE_W]),
            .a_drv (a_drv[g]),
            .b_out (b_out[g*LANE_W +: LANE_W]),
            .b_drv (b_drv[g])
        );
    end

    // Total width check at elaboration.
    initial begin
        if (W != $bits(a_in)) $display("xcvr_bus: width mismatch");
    end
endmodule

// File: rtl/xcvr_bus_chk.sv
// Checker bound to xcvr_bus: enable rules, capture results and register hold.
// Assumes: it watches only the top-level ports.
module xcvr_bus_chk #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [LANES-1:0]        oe_n,
    input logic [LANES-1:0]        dir,
    input logic [LANES-1:0]        cap_ab,
    input logic [LANES-1:0]        cap_ba,
    input logic [LANES-1:0]        sel_ab,
    input logic [LANES-1:0]        sel_ba,
    input logic [LANES*LANE_W-1:0] a_in,
    input logic [LANES*LANE_W-1:0] b_in,
    input logic [LANES*LANE_W-1:0] a_out,
    input logic [LANES-1:0]        a_drv,
    input logic [LANES*LANE_W-1:0] b_out,
    input logic [LANES-1:0]        b_drv
);
    logic                 rst_q;
    logic [LANES-1:0]     cab_q, cba_q, rab_q, rba_q;

    // Checker-side strobe history and reset history.
    always_ff @(posedge clk) begin
        rst_q <= rst_n;
        cab_q <= cap_ab;
        cba_q <= cap_ba;
        if (!rst_n) begin
            rab_q <= '0;
            rba_q <= '0;
        end else begin
            rab_q <= cap_ab & ~cab_q;
            rba_q <= cap_ba & ~cba_q;
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_chk
        assert_isolate_R4: assert property (@(posedge clk) disable iff (!rst_n)
            oe_n[i] |-> (!a_drv[i] && !b_drv[i]));

        assert_one_side_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !oe_n[i] |-> ((a_drv[i] != b_drv[i]) && (b_drv[i] == dir[i])));

        assert_cap_ab_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_q && rab_q[i] && sel_ab[i])
            |-> (b_out[i*LANE_W +: LANE_W] == $past(a_in[i*LANE_W +: LANE_W])));

        assert_cap_ba_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_q && rba_q[i] && sel_ba[i])
            |-> (a_out[i*LANE_W +: LANE_W] == $past(b_in[i*LANE_W +: LANE_W])));

        assert_hold_ab_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_q && sel_ab[i] && $past(sel_ab[i]) && !rab_q[i])
            |-> $stable(b_out[i*LANE_W +: LANE_W]));

        assert_hold_ba_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (rst_q && sel_ba[i] && $past(sel_ba[i]) && !rba_q[i])
            |-> $stable(a_out[i*LANE_W +: LANE_W]));
    end
endmodule

bind xcvr_bus xcvr_bus_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .oe_n   (oe_n),
    .dir    (dir),
    .cap_ab (cap_ab),
    .cap_ba (cap_ba),
    .sel_ab (sel_ab),
    .sel_ba (sel_ba),
    .a_in   (a_in),
    .b_in   (b_in),
    .a_out  (a_out),
    .a_drv  (a_drv),
    .b_out  (b_out),
    .b_drv  (b_drv)
);

// File: tb/tb_xcvr_bus.sv
`timescale 1ns/1ps
module tb_xcvr_bus;
    localparam int LANES = 2;
    localparam int LW    = 8;
    localparam int W     = LANES * LW;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n;
    logic [LANES-1:0] oe_n, dir, cap_ab, cap_ba, sel_ab, sel_ba, a_drv, b_drv;
    logic [W-1:0]     a_in, b_in, a_out, b_out;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    // Reference state computed from the requirements.
    logic [LW-1:0]    m_ab [LANES];
    logic [LW-1:0]    m_ba [LANES];
    logic [LANES-1:0] m_pab, m_pba;

    xcvr_bus #(.LANES(LANES), .LANE_W(LW)) dut (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir),
        .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_drv(a_drv),
        .b_out(b_out), .b_drv(b_drv)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Next register state for the coming edge (R2, R3, R9, R10).
    task automatic model_edge();
        for (int l = 0; l < LANES; l++) begin
            if (!rst_n) begin
                m_ab[l] = '0;
                m_ba[l] = '0;
            end else begin
                if (cap_ab[l] && !m_pab[l]) m_ab[l] = a_in[l*LW +: LW];
                if (cap_ba[l] && !m_pba[l]) m_ba[l] = b_in[l*LW +: LW];
            end
            m_pab[l] = cap_ab[l];
            m_pba[l] = cap_ba[l];
        end
    endtask

    function automatic logic [LW-1:0] exp_b(int l);
        return sel_ab[l] ? m_ab[l] : a_in[l*LW +: LW];
    endfunction

    function automatic logic [LW-1:0] exp_a(int l);
        return sel_ba[l] ? m_ba[l] : b_in[l*LW +: LW];
    endfunction

    // Compare every lane output against the reference (R1, R4 to R7).
    task automatic compare_all();
        for (int l = 0; l < LANES; l++) begin
            chk("R6/R1 b_out", b_out[l*LW +: LW], exp_b(l));
            chk("R7/R1 a_out", a_out[l*LW +: LW], exp_a(l));
            chk(oe_n[l] ? "R4 b_drv" : "R5 b_drv", b_drv[l], !oe_n[l] && dir[l]);
            chk(oe_n[l] ? "R4 a_drv" : "R5 a_drv", a_drv[l], !oe_n[l] && !dir[l]);
        end
    endtask

    // One clock: update the reference, wait for the edge, sample 1 ns later.
    task automatic cycle();
        model_edge();
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic idle();
        oe_n = '1; dir = '0; cap_ab = '0; cap_ba = '0; sel_ab = '0; sel_ba = '0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        a_in = '0; b_in = '0; rst_n = 1'b0;
        m_pab = '0; m_pba = '0;
        for (int l = 0; l < LANES; l++) begin m_ab[l] = '0; m_ba[l] = '0; end
        repeat (3) cycle();

        // R9: reset state seen through stored select.
        rst_n = 1'b1; sel_ab = '1; sel_ba = '1; a_in = 16'hFFFF; b_in = 16'hFFFF;
        cycle();
        chk("R9 b_out after reset", b_out, 16'h0000);
        chk("R9 a_out after reset", a_out, 16'h0000);
        chk("R4 drives off while isolated", {a_drv, b_drv}, 4'b0000);

        // R2 with R1: capture lane 0 only, then change input.
        a_in = 16'hA55A; cap_ab = 2'b01;
        cycle();
        cap_ab = 2'b00; a_in = 16'h1234;
        cycle();
        chk("R2 lane0 stored", b_out[7:0], 8'h5A);
        chk("R1 lane1 untouched", b_out[15:8], 8'h00);

        // R10: strobe held high captures once.
        a_in = 16'hC300; cap_ab = 2'b10;
        cycle();
        a_in = 16'h9900;
        repeat (3) cycle();
        chk("R10 held strobe", b_out[15:8], 8'hC3);

        // R8 and R3: capture while isolated, then enable A side with stored select.
        cap_ab = '0; oe_n = 2'b11; b_in = 16'h7E81; cap_ba = 2'b11;
        cycle();
        cap_ba = 2'b00; b_in = 16'h0000; oe_n = 2'b00; dir = 2'b00; sel_ba = 2'b11;
        cycle();
        chk("R8 isolated capture shown", a_out, 16'h7E81);
        chk("R8 A side driven", a_drv, 2'b11);
        chk("R3 lane0 stored", a_out[7:0], 8'h81);

        // R9: strobe held high through reset release does not capture.
        cap_ab = 2'b11; rst_n = 1'b0;
        cycle();
        rst_n = 1'b1; a_in = 16'hBEEF; sel_ab = 2'b11;
        cycle();
        chk("R9 no capture on release", b_out, 16'h0000);
        cap_ab = '0;
        cycle();

        // R4 R5 R6 R7: all enable/direction/select combinations per lane.
        for (int l = 0; l < LANES; l++) begin
            for (int c = 0; c < 8; c++) begin
                oe_n[l] = c[2]; dir[l] = c[1]; sel_ab[l] = c[0]; sel_ba[l] = c[0];
                a_in = 16'($urandom); b_in = 16'($urandom);
                cycle();
            end
        end

        // Random stretch, lanes driven independently.
        for (int n = 0; n < 3000; n++) begin
            oe_n   = 2'($urandom); dir    = 2'($urandom);
            sel_ab = 2'($urandom); sel_ba = 2'($urandom);
            cap_ab = 2'($urandom); cap_ba = 2'($urandom);
            a_in   = 16'($urandom); b_in  = 16'($urandom);
            rst_n  = ($urandom_range(0, 99) != 0);
            cycle();
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule